// File: doc/BRIEF.md
# Effective Address Generator with Pointer Fetch

This block forms the 24-bit effective address, or the immediate value, for a 16-bit accumulator processor that has a data bank register, a program bank register, a relocatable direct page and an emulation mode. Decode presents an addressing-mode code, the operand bytes already taken from the instruction stream, the index registers, the direct-page base, the stack pointer, both bank registers, the current program counter and the mode bits, and pulses `start`.

Modes that need no memory access are resolved in one cycle. Indirect modes, and the implied and accumulator modes with their single dummy read, run a short sequencer. It issues byte reads over a request/response port, assembles a little-endian pointer and then applies the bank and index rules of the mode. A one-cycle `done` strobe marks a valid `ea`. An unknown mode code gives address zero with `err` raised and never hangs.

Top module: `addr_gen_unit`

## Requirements
- R1: Mode 0 gives {data bank, operand[15:0]}. Mode 5 gives {program bank, operand[15:0]}. Modes 3 and 6 pass all 24 operand bits through.
- R2: Modes 1 and 2 add X or Y to {data bank, operand[15:0]}, and mode 4 adds X to the 24-bit operand. Only the low 24 bits are kept, so a carry reaches the bank byte.
- R3: The direct modes 12, 13 and 14 use offsets operand[7:0], operand[7:0]+X and operand[7:0]+Y. Each result is {8'h00, (D + offset) mod 2^16}.
- R4: When emulation is set and D[7:0] is zero, every direct-page address is {D[15:8], offset[7:0]}. This applies to each pointer byte of the direct indirect modes, so the byte after offset FF is read at offset 00 of the same page. With a nonzero D low byte the plain sum of R3 applies.
- R5: Mode 27 gives zero. Mode 28 gives {8'h00, (operand[7:0] + SP) mod 2^16}.
- R6: Mode 20 gives operand[7:0] and mode 21 gives operand[15:0], both zero-extended. Mode 22 gives 8 bits when the accumulator-width flag is set and 16 bits when it is clear. Mode 23 follows the index-width flag in the same way. Mode 24 gives operand[7:0], and modes 25 and 26 give operand[15:0].
- R7: Pointer bytes are read one at a time. `mem_req` is high for one cycle with `mem_addr`, and the byte on `mem_rdata` in the next cycle is taken. The next request follows a cycle later. Bytes come from consecutive addresses, lowest first, and are assembled little-endian.
- R8: Modes 15 and 16 read a 2-byte pointer at direct offsets operand[7:0] and operand[7:0]+X, and give {data bank, pointer}. Mode 17 adds Y to that result. Mode 18 reads a 3-byte pointer and returns it, and mode 19 adds Y to it. All sums are kept to 24 bits.
- R9: Mode 7 reads a 2-byte pointer at {program bank, (operand[15:0]+X) mod 2^16} and gives {program bank, pointer}. Mode 8 reads a 2-byte pointer at {8'h00, operand[15:0]} and gives {program bank, pointer}. Mode 9 reads a 3-byte pointer at {8'h00, operand[15:0]} and returns it.
- R10: Mode 29 reads a 2-byte pointer at {8'h00, (operand[7:0]+SP) mod 2^16}, applies the data bank and adds Y, keeping 24 bits.
- R11: Modes 10 and 11 make exactly one read at {program bank, PC} and give zero.
- R12: Codes 30 and 31 give `ea` zero with `err` high, make no read, and finish like a one-cycle mode. Every defined mode gives `err` low.
- R13: `done` is high for one cycle per accepted start. It is high in the cycle after `start` for modes without reads, and 2n+1 cycles after that for a mode making n reads. `start` has no effect while a fetch is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin address generation with the presented inputs |
| mode | input | 5 | Addressing-mode code |
| opnd | input | 24 | Operand bytes, first byte in bits 7:0 |
| idx_x | input | 16 | X index register |
| idx_y | input | 16 | Y index register |
| dpage | input | 16 | Direct-page base |
| stkp | input | 16 | Stack pointer |
| dbank | input | 8 | Data bank register |
| pbank | input | 8 | Program bank register |
| pcur | input | 16 | Current program counter |
| emu | input | 1 | Emulation mode |
| acc8 | input | 1 | Accumulator width flag, set for 8-bit |
| idx8 | input | 1 | Index width flag, set for 8-bit |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 24 | Byte read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| done | output | 1 | One-cycle strobe, result valid |
| ea | output | 24 | Effective address or immediate value |
| err | output | 1 | Undefined mode code |

## Verification
The hardest case to reach is the page wrap in the middle of a pointer fetch. It needs emulation set, a page-aligned direct base, and an offset of FF so that only the second byte's address crosses back to the start of the page. The stimulus sets exactly that and checks both logged read addresses as well as the assembled result. A second hard case is a start held high with a different mode while a fetch is running. The bench keeps `start` asserted across the busy cycles and expects a single `done` that carries the indirect result.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int ADDR_W    = 24;
    localparam int WORD_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int MODE_W    = 5;
    localparam int PTR_BYTES = 3;
    localparam int CNT_W     = $clog2(PTR_BYTES + 1);
    localparam int BANK_W    = ADDR_W - WORD_W;

    typedef enum logic [MODE_W-1:0] {
        AM_ABS          = 5'd0,
        AM_ABS_X        = 5'd1,
        AM_ABS_Y        = 5'd2,
        AM_LONG         = 5'd3,
        AM_LONG_X       = 5'd4,
        AM_ABS_JMP      = 5'd5,
        AM_LONG_JMP     = 5'd6,
        AM_ABS_X_IND    = 5'd7,
        AM_ABS_IND      = 5'd8,
        AM_ABS_IND_LONG = 5'd9,
        AM_ACC          = 5'd10,
        AM_IMPL         = 5'd11,
        AM_DP           = 5'd12,
        AM_DP_X         = 5'd13,
        AM_DP_Y         = 5'd14,
        AM_DP_IND       = 5'd15,
        AM_DP_X_IND     = 5'd16,
        AM_DP_IND_Y     = 5'd17,
        AM_DP_IND_LONG  = 5'd18,
        AM_DP_IND_LONGY = 5'd19,
        AM_IMM8         = 5'd20,
        AM_IMM16        = 5'd21,
        AM_IMM_ACC      = 5'd22,
        AM_IMM_IDX      = 5'd23,
        AM_REL8         = 5'd24,
        AM_REL16        = 5'd25,
        AM_BLOCK        = 5'd26,
        AM_STACK        = 5'd27,
        AM_SR           = 5'd28,
        AM_SR_IND_Y     = 5'd29
    } agu_mode_e;

    typedef struct packed {
        agu_mode_e          mode;
        logic [ADDR_W-1:0]  opnd;
        logic [WORD_W-1:0]  xr;
        logic [WORD_W-1:0]  yr;
        logic [WORD_W-1:0]  dr;
        logic [WORD_W-1:0]  sp;
        logic [WORD_W-1:0]  pc;
        logic [BANK_W-1:0]  db;
        logic [BANK_W-1:0]  pb;
        logic               emu;
        logic               acc8;
        logic               idx8;
    } agu_ctx_t;

    typedef struct packed {
        logic [ADDR_W-1:0]  ea;
        logic               err;
        logic [CNT_W-1:0]   nbytes;
        logic               use_dp;
        logic [WORD_W-1:0]  dp_off;
        logic [ADDR_W-1:0]  base;
    } agu_plan_t;

    // Direct-page address: page-locked in emulation with an aligned base.
    function automatic logic [WORD_W-1:0] dp_addr(
        input logic [WORD_W-1:0] d,
        input logic [WORD_W-1:0] off,
        input logic              emu
    );
        if (emu && (d[BYTE_W-1:0] == '0))
            return {d[WORD_W-1:BYTE_W], off[BYTE_W-1:0]};
        else
            return d + off;
    endfunction

    // Final address of a fetched-pointer mode.
    function automatic logic [ADDR_W-1:0] ptr_result(
        input agu_mode_e          m,
        input logic [BANK_W-1:0]  db,
        input logic [BANK_W-1:0]  pb,
        input logic [WORD_W-1:0]  y,
        input logic [ADDR_W-1:0]  ptr
    );
        logic [ADDR_W-1:0] yext;
        yext = {{BANK_W{1'b0}}, y};
        case (m)
            AM_ABS_X_IND, AM_ABS_IND:       return {pb, ptr[WORD_W-1:0]};
            AM_ABS_IND_LONG, AM_DP_IND_LONG: return ptr;
            AM_DP_IND, AM_DP_X_IND:         return {db, ptr[WORD_W-1:0]};
            AM_DP_IND_Y, AM_SR_IND_Y:       return {db, ptr[WORD_W-1:0]} + yext;
            AM_DP_IND_LONGY:                return ptr + yext;
            default:                        return '0;
        endcase
    endfunction

endpackage

// File: rtl/agu_mode_decode.sv
module agu_mode_decode
    import agu_pkg::*;
(
    input  agu_ctx_t  ctx,
    output agu_plan_t plan
);

    logic [ADDR_W-1:0] xext, yext, dbabs, longop;
    logic [WORD_W-1:0] off8, off8x, off8y, srsum;

    assign xext   = {{BANK_W{1'b0}}, ctx.xr};
    assign yext   = {{BANK_W{1'b0}}, ctx.yr};
    assign dbabs  = {ctx.db, ctx.opnd[WORD_W-1:0]};
    assign longop = ctx.opnd;
    assign off8   = {{(WORD_W-BYTE_W){1'b0}}, ctx.opnd[BYTE_W-1:0]};
    assign off8x  = off8 + ctx.xr;
    assign off8y  = off8 + ctx.yr;
    assign srsum  = off8 + ctx.sp;

    always_comb begin
        plan = '0;
        case (ctx.mode)
            AM_ABS:      plan.ea = dbabs;
            AM_ABS_X:    plan.ea = dbabs + xext;
            AM_ABS_Y:    plan.ea = dbabs + yext;
            AM_LONG:     plan.ea = longop;
            AM_LONG_X:   plan.ea = longop + xext;
            AM_ABS_JMP:  plan.ea = {ctx.pb, ctx.opnd[WORD_W-1:0]};
            AM_LONG_JMP: plan.ea = longop;
            AM_ABS_X_IND: begin
                plan.nbytes = CNT_W'(2);
                plan.base   = {ctx.pb, ctx.opnd[WORD_W-1:0] + ctx.xr};
            end
            AM_ABS_IND: begin
                plan.nbytes = CNT_W'(2);
                plan.base   = {{BANK_W{1'b0}}, ctx.opnd[WORD_W-1:0]};
            end
            AM_ABS_IND_LONG: begin
                plan.nbytes = CNT_W'(3);
                plan.base   = {{BANK_W{1'b0}}, ctx.opnd[WORD_W-1:0]};
            end
            AM_ACC, AM_IMPL: begin
                plan.nbytes = CNT_W'(1);
                plan.base   = {ctx.pb, ctx.pc};
            end
            AM_DP:   plan.ea = {{BANK_W{1'b0}}, dp_addr(ctx.dr, off8, ctx.emu)};
            AM_DP_X: plan.ea = {{BANK_W{1'b0}}, dp_addr(ctx.dr, off8x, ctx.emu)};
            AM_DP_Y: plan.ea = {{BANK_W{1'b0}}, dp_addr(ctx.dr, off8y, ctx.emu)};
            AM_DP_IND, AM_DP_IND_Y: begin
                plan.nbytes = CNT_W'(2);
                plan.use_dp = 1'b1;
                plan.dp_off = off8;
            end
            AM_DP_X_IND: begin
                plan.nbytes = CNT_W'(2);
                plan.use_dp = 1'b1;
                plan.dp_off = off8x;
            end
            AM_DP_IND_LONG, AM_DP_IND_LONGY: begin
                plan.nbytes = CNT_W'(3);
                plan.use_dp = 1'b1;
                plan.dp_off = off8;
            end
            AM_IMM8:    plan.ea = {{(ADDR_W-BYTE_W){1'b0}}, ctx.opnd[BYTE_W-1:0]};
            AM_IMM16:   plan.ea = {{BANK_W{1'b0}}, ctx.opnd[WORD_W-1:0]};
            AM_IMM_ACC: plan.ea = ctx.acc8 ? {{(ADDR_W-BYTE_W){1'b0}}, ctx.opnd[BYTE_W-1:0]}
                                           : {{BANK_W{1'b0}}, ctx.opnd[WORD_W-1:0]};
            AM_IMM_IDX: plan.ea = ctx.idx8 ? {{(ADDR_W-BYTE_W){1'b0}}, ctx.opnd[BYTE_W-1:0]}
                                           : {{BANK_W{1'b0}}, ctx.opnd[WORD_W-1:0]};
            AM_REL8:    plan.ea = {{(ADDR_W-BYTE_W){1'b0}}, ctx.opnd[BYTE_W-1:0]};
            AM_REL16, AM_BLOCK: plan.ea = {{BANK_W{1'b0}}, ctx.opnd[WORD_W-1:0]};
            AM_STACK:   plan.ea = '0;
            AM_SR:      plan.ea = {{BANK_W{1'b0}}, srsum};
            AM_SR_IND_Y: begin
                plan.nbytes = CNT_W'(2);
                plan.base   = {{BANK_W{1'b0}}, srsum};
            end
            default:    plan.err = 1'b1;
        endcase
    end

endmodule

// File: rtl/agu_fetch_seq.sv
module agu_fetch_seq
    import agu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [CNT_W-1:0]  nbytes,
    input  logic              use_dp,
    input  logic [WORD_W-1:0] dp_off,
    input  logic [ADDR_W-1:0] base,
    input  logic [WORD_W-1:0] dpage,
    input  logic              emu,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] ptr,
    output logic              fin,
    output logic              busy
);

    typedef enum logic [1:0] {S_IDLE, S_REQ, S_CAP, S_FIN} seq_st_e;

    seq_st_e            st;
    logic [CNT_W-1:0]   idx;
    logic [ADDR_W-1:0]  addr_c;
    logic               last;

    always_comb begin
        if (use_dp)
            addr_c = {{BANK_W{1'b0}},
                      dp_addr(dpage, dp_off + {{(WORD_W-CNT_W){1'b0}}, idx}, emu)};
        else
            addr_c = base + {{(ADDR_W-CNT_W){1'b0}}, idx};
    end

    assign last     = (idx == nbytes - CNT_W'(1));
    assign mem_req  = (st == S_REQ);
    assign mem_addr = mem_req ? addr_c : '0;
    assign fin      = (st == S_FIN);
    assign busy     = (st != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= S_IDLE;
            idx <= '0;
        end else begin
            case (st)
                S_IDLE: if (go) begin
                    st  <= S_REQ;
                    idx <= '0;
                end
                S_REQ:  st <= S_CAP;
                S_CAP:  if (last) st <= S_FIN;
                        else begin
                            idx <= idx + CNT_W'(1);
                            st  <= S_REQ;
                        end
                default: st <= S_IDLE;
            endcase
        end
    end

    // One byte lane per pointer byte.
    for (genvar g = 0; g < PTR_BYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || (st == S_IDLE && go))
                ptr[g*BYTE_W +: BYTE_W] <= '0;
            else if (st == S_CAP && idx == CNT_W'(g))
                ptr[g*BYTE_W +: BYTE_W] <= mem_rdata;
        end
    end

    // R7: a request never lasts two cycles in a row
    assert_req_gap_R7: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R4: page-locked reads stay inside the direct page in bank zero
    assert_page_lock_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && use_dp && emu && dpage[BYTE_W-1:0] == '0)
        |-> (mem_addr[ADDR_W-1:BYTE_W] == {{BANK_W{1'b0}}, dpage[WORD_W-1:BYTE_W]}));

endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit
    import agu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [ADDR_W-1:0] opnd,
    input  logic [WORD_W-1:0] idx_x,
    input  logic [WORD_W-1:0] idx_y,
    input  logic [WORD_W-1:0] dpage,
    input  logic [WORD_W-1:0] stkp,
    input  logic [BANK_W-1:0] dbank,
    input  logic [BANK_W-1:0] pbank,
    input  logic [WORD_W-1:0] pcur,
    input  logic              emu,
    input  logic              acc8,
    input  logic              idx8,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              done,
    output logic [ADDR_W-1:0] ea,
    output logic              err
);

    agu_ctx_t  ctx_in;
    agu_plan_t plan;

    assign ctx_in = '{mode: agu_mode_e'(mode), opnd: opnd, xr: idx_x, yr: idx_y,
                      dr: dpage, sp: stkp, pc: pcur, db: dbank, pb: pbank,
                      emu: emu, acc8: acc8, idx8: idx8};

    agu_mode_decode u_dec (
        .ctx  (ctx_in),
        .plan (plan)
    );

    logic [MODE_W-1:0] mode_q;
    logic [BANK_W-1:0] db_q, pb_q;
    logic [WORD_W-1:0] y_q, off_q, d_q;
    logic [CNT_W-1:0]  nb_q;
    logic              dp_q, emu_q;
    logic [ADDR_W-1:0] base_q;
    logic              accept, go, busy, fin;
    logic [ADDR_W-1:0] ptr;

    assign accept = start && !busy;
    assign go     = accept && (plan.nbytes != '0);

    agu_fetch_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .nbytes    (nb_q),
        .use_dp    (dp_q),
        .dp_off    (off_q),
        .base      (base_q),
        .dpage     (d_q),
        .emu       (emu_q),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .ptr       (ptr),
        .fin       (fin),
        .busy      (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            db_q   <= '0;
            pb_q   <= '0;
            y_q    <= '0;
            nb_q   <= '0;
            dp_q   <= 1'b0;
            off_q  <= '0;
            base_q <= '0;
            d_q    <= '0;
            emu_q  <= 1'b0;
            done   <= 1'b0;
            ea     <= '0;
            err    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                mode_q <= mode;
                db_q   <= dbank;
                pb_q   <= pbank;
                y_q    <= idx_y;
                nb_q   <= plan.nbytes;
                dp_q   <= plan.use_dp;
                off_q  <= plan.dp_off;
                base_q <= plan.base;
                d_q    <= dpage;
                emu_q  <= emu;
                if (plan.nbytes == '0) begin
                    done <= 1'b1;
                    ea   <= plan.ea;
                    err  <= plan.err;
                end
            end else if (fin) begin
                done <= 1'b1;
                ea   <= ptr_result(agu_mode_e'(mode_q), db_q, pb_q, y_q, ptr);
                err  <= 1'b0;
            end
        end
    end

    // R12: an error result carries address zero
    assert_err_zero_R12: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (ea == '0));

    // R12: error only for the two undefined codes
    assert_err_code_R12: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (mode_q >= MODE_W'(30)));

    // R6: fixed 8-bit immediates never set the upper bits
    assert_imm8_width_R6: assert property (@(posedge clk) disable iff (rst)
        (done && mode_q == MODE_W'(AM_IMM8)) |-> (ea[ADDR_W-1:BYTE_W] == '0));

    // R13: the strobe comes only once the fetcher is idle and quiet
    assert_done_idle_R13: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !mem_req));

endmodule

// File: tb/test_addr_gen_unit.sv
module test_addr_gen_unit;

    logic        clk = 1'b0;
    logic        rst, start;
    logic [4:0]  mode;
    logic [23:0] opnd;
    logic [15:0] xr, yr, dr, spr, pcr;
    logic [7:0]  dbr, pbr;
    logic        emu, m8, x8;
    logic [7:0]  mem_rdata;
    logic        mem_req, done, err;
    logic [23:0] mem_addr, ea;

    int checks = 0;
    int errors = 0;
    int nrd = 0;
    int lat = 0;
    logic [23:0] rlog [0:3];
    logic [23:0] got_ea;
    logic        got_err;

    always #5 clk = ~clk;

    addr_gen_unit i_addr_gen_unit (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .opnd(opnd),
        .idx_x(xr), .idx_y(yr), .dpage(dr), .stkp(spr), .dbank(dbr),
        .pbank(pbr), .pcur(pcr), .emu(emu), .acc8(m8), .idx8(x8),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .done(done), .ea(ea), .err(err)
    );

    function automatic logic [7:0] mb(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    // memory model: data one cycle after the request
    always @(posedge clk) begin
        if (mem_req) begin
            if (nrd < 4) rlog[nrd] = mem_addr;
            nrd = nrd + 1;
            mem_rdata <= mb(mem_addr);
        end
    end

    // {mode, operand, expected ea, expected err}
    localparam logic [53:0] VT [0:20] = '{
        {5'd0,  24'h001234, 24'h7E1234, 1'b0},  // R1
        {5'd1,  24'h00FFF8, 24'h7F0008, 1'b0},  // R2 carry into bank
        {5'd2,  24'h001000, 24'h7E1020, 1'b0},  // R2
        {5'd3,  24'h123456, 24'h123456, 1'b0},  // R1
        {5'd4,  24'hFFFFF8, 24'h000008, 1'b0},  // R2 24-bit wrap
        {5'd5,  24'h004567, 24'h034567, 1'b0},  // R1
        {5'd6,  24'hABCDEF, 24'hABCDEF, 1'b0},  // R1
        {5'd12, 24'h000034, 24'h001234, 1'b0},  // R3
        {5'd13, 24'h0000F8, 24'h001308, 1'b0},  // R3
        {5'd14, 24'h000005, 24'h001225, 1'b0},  // R3
        {5'd20, 24'h77CCAB, 24'h0000AB, 1'b0},  // R6
        {5'd21, 24'h77CCAB, 24'h00CCAB, 1'b0},  // R6
        {5'd22, 24'h77CCAB, 24'h0000AB, 1'b0},  // R6 acc8 set
        {5'd23, 24'h77CCAB, 24'h00CCAB, 1'b0},  // R6 idx8 clear
        {5'd24, 24'h1122FE, 24'h0000FE, 1'b0},  // R6
        {5'd25, 24'h1122FE, 24'h0022FE, 1'b0},  // R6
        {5'd26, 24'h1122FE, 24'h0022FE, 1'b0},  // R6
        {5'd27, 24'h123456, 24'h000000, 1'b0},  // R5
        {5'd28, 24'h000020, 24'h000210, 1'b0},  // R5
        {5'd30, 24'h123456, 24'h000000, 1'b1},  // R12
        {5'd31, 24'hFFFFFF, 24'h000000, 1'b1}   // R12
    };

    task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic defaults();
        xr = 16'h0010; yr = 16'h0020; dr = 16'h1200; spr = 16'h01F0;
        pcr = 16'h8000; dbr = 8'h7E; pbr = 8'h03; emu = 1'b0; m8 = 1'b1; x8 = 1'b0;
    endtask

    task automatic run(input logic [4:0] m, input logic [23:0] op);
        @(negedge clk);
        mode = m; opnd = op; start = 1'b1; nrd = 0;
        @(negedge clk);
        start = 1'b0; lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        got_ea = ea; got_err = err;
    endtask

    task automatic run_ind(input string r, input logic [4:0] m, input logic [23:0] op,
                           input int n, input logic [23:0] a0, input logic [23:0] a1,
                           input logic [23:0] a2, input logic [23:0] exp_ea);
        logic [23:0] al [0:2];
        al[0] = a0; al[1] = a1; al[2] = a2;
        run(m, op);
        check({r, " read count"}, nrd, n);
        for (int i = 0; i < n; i++) check({r, " read address"}, rlog[i], al[i]);
        check({r, " ea"}, got_ea, exp_ea);
        check({r, " err"}, got_err, 1'b0);
        check({r, " R13 latency"}, lat, 2 * n + 2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [23:0] a0, a1, a2;
        int ndone;
        defaults();
        rst = 1'b1; start = 1'b0; mode = '0; opnd = '0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R13 reset done", done, 1'b0);
        check("R7 reset mem_req", mem_req, 1'b0);
        check("R12 reset err", err, 1'b0);

        for (int i = 0; i < 21; i++) begin
            logic [53:0] v;
            v = VT[i];
            run(v[53:49], v[48:25]);
            check("R1/R2/R3/R5/R6/R12 table ea", got_ea, v[24:1]);
            check("R12 table err", got_err, v[0]);
            check("R13 table latency", lat, 1);
            check("R12 table no read", nrd, 0);
        end

        // R3 16-bit truncation of the direct sum
        dr = 16'hFFF0; run(5'd12, 24'h000020);
        check("R3 direct wrap", got_ea, 24'h000010);

        // R4 page lock and its absence
        emu = 1'b1; dr = 16'h1200; run(5'd13, 24'h0000F8);
        check("R4 page locked", got_ea, 24'h001208);
        dr = 16'h1201; run(5'd13, 24'h0000F8);
        check("R4 unaligned base", got_ea, 24'h001309);
        defaults();

        // R6 width flags the other way
        m8 = 1'b0; x8 = 1'b1;
        run(5'd22, 24'h77CCAB); check("R6 acc16", got_ea, 24'h00CCAB);
        run(5'd23, 24'h77CCAB); check("R6 idx8", got_ea, 24'h0000AB);
        defaults();

        // R7/R8 direct indirect
        a0 = 24'h001240; a1 = 24'h001241; a2 = 24'h001242;
        run_ind("R7 R8 dp ind", 5'd15, 24'h000040, 2, a0, a1, a2, {8'h7E, mb(a1), mb(a0)});
        run_ind("R8 dp x ind", 5'd16, 24'h000030, 2, a0, a1, a2, {8'h7E, mb(a1), mb(a0)});
        run_ind("R8 dp ind y", 5'd17, 24'h000040, 2, a0, a1, a2,
                {8'h7E, mb(a1), mb(a0)} + 24'h000020);
        run_ind("R8 dp ind long", 5'd18, 24'h000040, 3, a0, a1, a2, {mb(a2), mb(a1), mb(a0)});
        yr = 16'hFFFF;
        run_ind("R8 dp ind long y", 5'd19, 24'h000040, 3, a0, a1, a2,
                {mb(a2), mb(a1), mb(a0)} + 24'h00FFFF);
        defaults();

        // R4 wrap between the two pointer bytes
        emu = 1'b1;
        a0 = 24'h0012FF; a1 = 24'h001200;
        run_ind("R4 ind page wrap", 5'd15, 24'h0000FF, 2, a0, a1, a2, {8'h7E, mb(a1), mb(a0)});
        defaults();

        // R9 absolute indirect group
        a0 = 24'h035010; a1 = 24'h035011;
        run_ind("R9 abs x ind", 5'd7, 24'h005000, 2, a0, a1, a2, {8'h03, mb(a1), mb(a0)});
        a0 = 24'h006000; a1 = 24'h006001; a2 = 24'h006002;
        run_ind("R9 abs ind", 5'd8, 24'h006000, 2, a0, a1, a2, {8'h03, mb(a1), mb(a0)});
        run_ind("R9 abs ind long", 5'd9, 24'h006000, 3, a0, a1, a2, {mb(a2), mb(a1), mb(a0)});

        // R10 stack-relative indirect indexed
        a0 = 24'h000200; a1 = 24'h000201;
        run_ind("R10 sr ind y", 5'd29, 24'h000010, 2, a0, a1, a2,
                {8'h7E, mb(a1), mb(a0)} + 24'h000020);

        // R11 dummy read
        a0 = 24'h038000;
        run_ind("R11 implied", 5'd11, 24'h000000, 1, a0, a1, a2, 24'h000000);
        run_ind("R11 accumulator", 5'd10, 24'h000000, 1, a0, a1, a2, 24'h000000);

        // R13 start held with another mode while busy
        @(negedge clk);
        mode = 5'd15; opnd = 24'h000040; start = 1'b1; nrd = 0; ndone = 0;
        @(negedge clk);
        mode = 5'd0; opnd = 24'h001234;
        for (int c = 0; c < 12; c++) begin
            if (c == 3) start = 1'b0;
            if (done) begin
                ndone++;
                got_ea = ea;
            end
            @(negedge clk);
        end
        a0 = 24'h001240; a1 = 24'h001241;
        check("R13 busy start ignored, done count", ndone, 1);
        check("R13 busy start ignored, ea", got_ea, {8'h7E, mb(a1), mb(a0)});
        check("R13 busy start ignored, reads", nrd, 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule